// File: doc/BRIEF.md
# Memory-Backed Streaming Prefetch FIFO

This block presents an ordinary FIFO read port to a consumer while its producer side is an autonomous fill sequencer. After software-free configuration (a source byte address, a total word count, then a one-cycle start pulse) the sequencer streams a contiguous region of external memory into a single on-chip RAM that is managed as a circular buffer. The consumer pops words in address order and never sees the memory port.

Before each burst the sequencer computes the free space from the head and tail pointers, sizes the burst to the smaller of that free space and the words still to fetch, and issues block read requests (address plus word count) on a simple valid/ready request channel. Returned words arrive on a response channel in order. A burst that would run past the physical end of the buffer is issued as two requests split at the wrap point. The head pointer moves only once a whole burst has landed. When every word has been fetched and the buffer has drained, a done flag is raised.

Top module: `stream_prefetch_fifo`

## Requirements
- R1: While and after reset, before any start, popEmpty is 1, done is 0 and memReqValid is 0.
- R2: Words are popped in strictly ascending address order: the k-th word popped in a stream (k from 0) equals the memory word at startAddr + k*WORD_BYTES, and no word beyond the configured count is ever presented.
- R3: Every request carries a word count of at least 1 that never exceeds the words still unrequested in the stream nor the buffer space left after words already requested and not yet popped; with no pops the fill stops once exactly DEPTH words are held.
- R4: A request never crosses the end of the circular buffer (its start index within the buffer plus its length is at most DEPTH), so a burst that would wrap is issued as two requests; a request is held unchanged until memReqReady accepts it.
- R5: Words of a burst become visible to the consumer only after all of them have been received; popEmpty falls only in the cycle after a response word was taken.
- R6: done is 1 exactly when a stream has been started and every one of its words has been popped; it is 0 before the first start and throughout a stream, and no request is pending while it is 1.
- R7: A start pulse while words of the current stream remain to be fetched is ignored: the running stream continues unchanged.
- R8: A pop while popEmpty is 1 has no effect: the first word later popped is still the first word of the stream.
- R9: A start with a word count of zero issues no memory request and raises done in the next cycle.
- R10: Each request address equals startAddr + (words already requested in the stream)*WORD_BYTES, with WORD_BYTES = DATA_W/8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStart | input | 1 | One-cycle start pulse, taken only when no words remain to fetch |
| cfgAddr | input | ADDR_W | Byte address of the first word of the stream |
| cfgWords | input | CNT_W | Total number of words in the stream |
| popReq | input | 1 | Consumer pop request |
| popData | output | DATA_W | Word at the front of the FIFO |
| popEmpty | output | 1 | No word available to pop |
| done | output | 1 | Stream fully fetched and drained |
| memReqValid | output | 1 | Block read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Byte address of the block |
| memReqLen | output | DEPTH_LOG2+1 | Number of words in the block |
| memRspValid | input | 1 | A returned data word is valid |
| memRspData | input | DATA_W | Returned data word |

## Verification
A corrupted head, tail or write pointer shows up at the very next pop as a word out of address order or a repeated word, and a wrong words-left count shows as a request address or length that breaks the remaining-words bound at the next request, or as done rising a cycle early or late. A premature head update is caught the first time popEmpty falls before the last word of a burst has arrived. Random response latency, random request acceptance and random consumer stalls, including long full-buffer stalls, drive the pointers across the wrap point many times so that split requests and zero free space are reached.

// File: rtl/spf_pkg.sv
package spf_pkg;

  typedef enum logic [1:0] {
    ST_PLAN,
    ST_REQ,
    ST_RESP
  } spf_state_e;

  typedef struct packed {
    logic loadCfg;
    logic planBurst;
    logic reqFire;
    logic writeWord;
    logic nextSeg;
    logic commit;
  } spf_strobe_t;

endpackage

// File: rtl/spf_datapath.sv
module spf_datapath
  import spf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int DEPTH_LOG2 = 4,
  parameter int CNT_W      = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  spf_strobe_t           strb,
  input  logic [ADDR_W-1:0]     cfgAddr,
  input  logic [CNT_W-1:0]      cfgWords,
  input  logic                  popReq,
  input  logic [DATA_W-1:0]     memRspData,
  output logic [DATA_W-1:0]     popData,
  output logic                  popEmpty,
  output logic                  done,
  output logic [ADDR_W-1:0]     memReqAddr,
  output logic [DEPTH_LOG2:0]   memReqLen,
  output logic                  wordsLeftZero,
  output logic                  burstZero,
  output logic                  lastWord,
  output logic                  hasSecond
);

  localparam int DEPTH      = 1 << DEPTH_LOG2;
  localparam int IDX_W      = DEPTH_LOG2;
  localparam int PTR_W      = DEPTH_LOG2 + 1;
  localparam int WORD_BYTES = DATA_W / 8;

  logic [DATA_W-1:0] bufRam [DEPTH];

  logic [PTR_W-1:0]  head, tail, wrPtr;
  logic [PTR_W-1:0]  segLen, segLeft, burstRem, burstLen;
  logic [PTR_W-1:0]  freeSpace, toWrap, burst, seg1;
  logic [CNT_W-1:0]  wordsLeft;
  logic [ADDR_W-1:0] srcAddr, reqAddr;
  logic              started;
  logic              popFire;

  // Space left in the ring, distance to its physical end, and burst sizing.
  assign freeSpace = PTR_W'(DEPTH) - (head - tail);
  assign toWrap    = PTR_W'(DEPTH) - {1'b0, head[IDX_W-1:0]};
  assign burst     = (wordsLeft < CNT_W'(freeSpace)) ? wordsLeft[PTR_W-1:0] : freeSpace;
  assign seg1      = (burst < toWrap) ? burst : toWrap;

  assign popEmpty      = (head == tail);
  assign popFire       = popReq && !popEmpty;
  assign popData       = bufRam[tail[IDX_W-1:0]];
  assign wordsLeftZero = (wordsLeft == '0);
  assign burstZero     = (burst == '0);
  assign lastWord      = (segLeft == PTR_W'(1));
  assign hasSecond     = (burstRem != '0);
  assign done          = started && wordsLeftZero && popEmpty;
  assign memReqAddr    = reqAddr;
  assign memReqLen     = segLen;

  always_ff @(posedge clk) begin
    if (strb.writeWord) bufRam[wrPtr[IDX_W-1:0]] <= memRspData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head      <= '0;
      tail      <= '0;
      wrPtr     <= '0;
      segLen    <= '0;
      segLeft   <= '0;
      burstRem  <= '0;
      burstLen  <= '0;
      wordsLeft <= '0;
      srcAddr   <= '0;
      reqAddr   <= '0;
      started   <= 1'b0;
    end else begin
      if (strb.loadCfg) begin
        srcAddr   <= cfgAddr;
        wordsLeft <= cfgWords;
        started   <= 1'b1;
      end
      if (strb.planBurst) begin
        reqAddr  <= srcAddr;
        segLen   <= seg1;
        burstRem <= burst - seg1;
        burstLen <= burst;
        wrPtr    <= head;
      end
      if (strb.reqFire) segLeft <= segLen;
      if (strb.writeWord) begin
        wrPtr   <= wrPtr + PTR_W'(1);
        segLeft <= segLeft - PTR_W'(1);
      end
      if (strb.nextSeg) begin
        reqAddr  <= reqAddr + ADDR_W'(segLen) * ADDR_W'(WORD_BYTES);
        segLen   <= burstRem;
        burstRem <= '0;
      end
      if (strb.commit) begin
        head      <= head + burstLen;
        srcAddr   <= srcAddr + ADDR_W'(burstLen) * ADDR_W'(WORD_BYTES);
        wordsLeft <= wordsLeft - CNT_W'(burstLen);
      end
      if (popFire) tail <= tail + PTR_W'(1);
    end
  end

endmodule

// File: rtl/spf_ctrl.sv
module spf_ctrl
  import spf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgStart,
  input  logic        wordsLeftZero,
  input  logic        burstZero,
  input  logic        lastWord,
  input  logic        hasSecond,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output spf_strobe_t strb,
  output logic        memReqValid
);

  spf_state_e state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_PLAN: begin
        if (cfgStart && wordsLeftZero) begin
          strb.loadCfg = 1'b1;
        end else if (!burstZero) begin
          strb.planBurst = 1'b1;
          nextState      = ST_REQ;
        end
      end
      ST_REQ: begin
        if (memReqReady) begin
          strb.reqFire = 1'b1;
          nextState    = ST_RESP;
        end
      end
      ST_RESP: begin
        if (memRspValid) begin
          strb.writeWord = 1'b1;
          if (lastWord) begin
            if (hasSecond) begin
              strb.nextSeg = 1'b1;
              nextState    = ST_REQ;
            end else begin
              strb.commit = 1'b1;
              nextState   = ST_PLAN;
            end
          end
        end
      end
      default: nextState = ST_PLAN;
    endcase
  end

  assign memReqValid = (state == ST_REQ);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_PLAN;
    else       state <= nextState;
  end

endmodule

// File: rtl/stream_prefetch_fifo.sv
module stream_prefetch_fifo
  import spf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int DEPTH_LOG2 = 4,
  parameter int CNT_W      = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgStart,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [CNT_W-1:0]    cfgWords,
  input  logic                popReq,
  output logic [DATA_W-1:0]   popData,
  output logic                popEmpty,
  output logic                done,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [DEPTH_LOG2:0] memReqLen,
  input  logic                memRspValid,
  input  logic [DATA_W-1:0]   memRspData
);

  spf_strobe_t strb;
  logic        wordsLeftZero, burstZero, lastWord, hasSecond;

  spf_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cfgStart      (cfgStart),
    .wordsLeftZero (wordsLeftZero),
    .burstZero     (burstZero),
    .lastWord      (lastWord),
    .hasSecond     (hasSecond),
    .memReqReady   (memReqReady),
    .memRspValid   (memRspValid),
    .strb          (strb),
    .memReqValid   (memReqValid)
  );

  spf_datapath #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .DEPTH_LOG2 (DEPTH_LOG2),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .cfgAddr       (cfgAddr),
    .cfgWords      (cfgWords),
    .popReq        (popReq),
    .memRspData    (memRspData),
    .popData       (popData),
    .popEmpty      (popEmpty),
    .done          (done),
    .memReqAddr    (memReqAddr),
    .memReqLen     (memReqLen),
    .wordsLeftZero (wordsLeftZero),
    .burstZero     (burstZero),
    .lastWord      (lastWord),
    .hasSecond     (hasSecond)
  );

endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 5,
  parameter int DEPTH  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              popEmpty,
  input logic              done,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic [LEN_W-1:0]  memReqLen,
  input logic              memRspValid
);

  // R3: a request is never empty and never larger than the ring
  p_req_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqLen != '0 && memReqLen <= LEN_W'(DEPTH)));

  // R4: a pending request is held unchanged until accepted
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqLen)));

  // R5: new data becomes visible only right after a response word was taken
  p_visible_after_rsp_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(popEmpty) |-> $past(memRspValid));

  // R6: done implies a drained buffer and an idle request channel
  p_done_drained_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (popEmpty && !memReqValid));

endmodule

bind stream_prefetch_fifo spf_checker #(
  .ADDR_W (ADDR_W),
  .LEN_W  (DEPTH_LOG2 + 1),
  .DEPTH  (1 << DEPTH_LOG2)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .popEmpty    (popEmpty),
  .done        (done),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .memReqLen   (memReqLen),
  .memRspValid (memRspValid)
);

// File: tb/stream_prefetch_fifo_test.sv
module stream_prefetch_fifo_test;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 32;
  localparam int DEPTH_LOG2 = 4;
  localparam int CNT_W      = 16;
  localparam int DEPTH      = 1 << DEPTH_LOG2;
  localparam int WATCHDOG   = 20000;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                cfgStart = 1'b0;
  logic [ADDR_W-1:0]   cfgAddr = '0;
  logic [CNT_W-1:0]    cfgWords = '0;
  logic                popReq = 1'b0;
  logic [DATA_W-1:0]   popData;
  logic                popEmpty;
  logic                done;
  logic                memReqValid;
  logic                memReqReady = 1'b0;
  logic [ADDR_W-1:0]   memReqAddr;
  logic [DEPTH_LOG2:0] memReqLen;
  logic                memRspValid = 1'b0;
  logic [DATA_W-1:0]   memRspData = '0;

  stream_prefetch_fifo #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH_LOG2(DEPTH_LOG2), .CNT_W(CNT_W)
  ) uut (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgAddr(cfgAddr),
    .cfgWords(cfgWords), .popReq(popReq), .popData(popData),
    .popEmpty(popEmpty), .done(done), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memReqLen(memReqLen),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit timedOut = 0;
  int popRate = 0, rdyRate = 100, rspRate = 100;

  // reference model state
  logic [DATA_W-1:0] expQ[$];
  logic [ADDR_W-1:0] streamBase = '0;
  int  streamTotal = 0, streamReq = 0, streamPopped = 0;
  int  globalReq = 0, poppedTotal = 0, completed = 0;
  bit  started = 0, r8Watch = 0;
  // responder state
  logic [ADDR_W-1:0] pendAddr = '0;
  int  pendLeft = 0, pendWait = 0;
  // pending start request
  bit  startReq = 0, startTaken = 0;
  logic [ADDR_W-1:0] startAddr = '0;
  int  startWords = 0;

  function automatic logic [DATA_W-1:0] memWord(logic [ADDR_W-1:0] a);
    return (a * 32'h9E37_79B9) ^ 32'h5A5A_1234;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic step();
    logic expDone;
    logic [DATA_W-1:0] e;
    int len;
    @(negedge clk);
    cycles++;
    if (cycles > WATCHDOG) begin
      if (!timedOut) check(1'b0, "watchdog expired", cycles, WATCHDOG);
      timedOut = 1;
      return;
    end
    // R6: done tracked every clock
    expDone = started && (streamPopped == streamTotal);
    check(done === expDone, "R6 done flag", done, expDone);
    // R5: visible words never exceed fully received requests
    if (!popEmpty)
      check(poppedTotal < completed, "R5 word visible before burst complete", poppedTotal, completed);
    // consumer
    popReq = ($urandom_range(99) < popRate);
    if (popReq && !popEmpty) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 word beyond configured count", popData, 0);
      end else begin
        e = expQ.pop_front();
        check(popData === e, "R2 popped word order", popData, e);
        if (r8Watch) begin
          check(popData === memWord(streamBase), "R8 first word after empty pops", popData, memWord(streamBase));
          r8Watch = 0;
        end
      end
      poppedTotal++;
      streamPopped++;
    end
    // responder: data words
    memRspValid = 1'b0;
    if (pendLeft > 0) begin
      if (pendWait > 0) pendWait--;
      else if ($urandom_range(99) < rspRate) begin
        memRspValid = 1'b1;
        memRspData  = memWord(pendAddr);
        pendAddr    = pendAddr + 4;
        pendLeft--;
        if (pendLeft == 0) completed = globalReq;
      end
    end
    // responder: request acceptance
    memReqReady = 1'b0;
    if (pendLeft == 0 && memReqValid && $urandom_range(99) < rdyRate) begin
      memReqReady = 1'b1;
      len = int'(memReqLen);
      check(memReqAddr === streamBase + ADDR_W'(streamReq * 4), "R10 request address", memReqAddr, streamBase + ADDR_W'(streamReq * 4));
      check(len > 0 && len <= streamTotal - streamReq, "R3 length vs remaining", len, streamTotal - streamReq);
      check(len <= DEPTH - (globalReq - poppedTotal), "R3 length vs free space", len, DEPTH - (globalReq - poppedTotal));
      check((globalReq % DEPTH) + len <= DEPTH, "R4 request crosses ring end", (globalReq % DEPTH) + len, DEPTH);
      pendAddr  = memReqAddr;
      pendLeft  = len;
      pendWait  = $urandom_range(4);
      streamReq += len;
      globalReq += len;
    end
    // configuration
    cfgStart = startReq;
    if (startReq) begin
      cfgAddr  = startAddr;
      cfgWords = CNT_W'(startWords);
      if (startTaken) begin
        streamBase   = startAddr;
        streamTotal  = startWords;
        streamReq    = 0;
        streamPopped = 0;
        started      = 1;
        for (int i = 0; i < startWords; i++) expQ.push_back(memWord(startAddr + ADDR_W'(i * 4)));
      end
    end
    startReq = 0;
  endtask

  task automatic startStream(logic [ADDR_W-1:0] a, int n, bit taken);
    startReq = 1; startAddr = a; startWords = n; startTaken = taken;
    step();
  endtask

  task automatic runDrain();
    while (streamPopped < streamTotal && !timedOut) step();
    for (int i = 0; i < 3; i++) step();
  endtask

  initial begin
    int reqBefore;
    repeat (4) @(negedge clk);
    check(popEmpty === 1'b1, "R1 empty in reset", popEmpty, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(popEmpty === 1'b1, "R1 empty after reset", popEmpty, 1);
    check(done === 1'b0, "R1 done after reset", done, 0);
    check(memReqValid === 1'b0, "R1 no request after reset", memReqValid, 0);

    // R8: pops against an empty buffer
    popRate = 100;
    for (int i = 0; i < 5; i++) step();
    r8Watch = 1;

    // long stream with random stalls; a second start mid-stream (R7)
    popRate = 60; rdyRate = 70; rspRate = 70;
    startStream(32'h0000_1000, 40, 1);
    for (int i = 0; i < 6; i++) step();
    startStream(32'h0000_8000, 5, 0);
    runDrain();

    // R9: zero-length stream
    reqBefore = globalReq;
    startStream(32'h0000_3000, 0, 1);
    for (int i = 0; i < 20; i++) step();
    check(globalReq == reqBefore, "R9 zero-length issues no request", globalReq, reqBefore);
    check(done === 1'b1, "R9 done after zero-length start", done, 1);

    // consumer stalled: ring fills completely, wraps and splits requests
    popRate = 0;
    startStream(32'h0000_2004, 37, 1);
    for (int i = 0; i < 150; i++) step();
    check(globalReq - poppedTotal == DEPTH, "R3 fill stops at full ring", globalReq - poppedTotal, DEPTH);
    popRate = 30;
    runDrain();

    // fast memory, eager consumer
    popRate = 90; rdyRate = 100; rspRate = 100;
    startStream(32'h0000_4000, 50, 1);
    runDrain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule